// File: doc/BRIEF.md
# Endpoint buffer access controller

This block sits between a local microcontroller and the packet buffers of a device-side USB function. The microcontroller first writes a command byte. The byte selects one IN buffer for filling, one OUT buffer for draining, or a soft reset. A data phase follows, made of single strobes. Each strobe moves one byte or one 16-bit word through a pointer that advances by itself. Every buffer begins with a two-byte packet length stored little-endian, and the payload follows it. A data phase run by a DMA engine starts past that header.

An IN buffer is handed to the serial engine through a per-endpoint ready flag. The flag rises when the buffer is completely filled. It also rises when an external end-of-transfer ends a DMA fill early. In that case the block itself writes the number of stored payload bytes into the header. When a DMA engine reads an OUT buffer, the block marks the last payload data with an end-of-packet flag, using the stored length. The serial engine writes the OUT buffers, reads the IN buffers and acknowledges sent packets through a simple word-wide port.

Top module: `ep_buf_access`

## Requirements
- R1: After reset, `in_ready`, `acc_err`, `acc_ovf`, `acc_rvalid` and `acc_eop` are all 0.
- R2: Codes 0x01..0x0F open IN buffer `code-1` (0x01 is the control endpoint) for writing. Bytes are stored in strobe order from byte 0, and byte 2k lands in the low half of word k as seen on the serial-side read port.
- R3: Code 0x10 opens OUT buffer 0 and codes 0x12..0x1F open OUT buffer `code-0x11` for reading. Each `acc_rd` strobe returns the next data on `acc_rdata` with `acc_rvalid` one clock later. In byte mode the byte sits in bits 7:0.
- R4: The pointer advances 1 per strobe when `bus16`=0 at the command, and 2 per strobe (one word, low byte at the even address) when `bus16`=1.
- R5: A strobe that would pass byte N+2 (N = `MAX_PAYLOAD`), or a write in the cycle in which a buffer is being released, is ignored. It does not move the pointer and it sets `acc_ovf`.
- R6: A read strobe with no read session open, or a write strobe with no write session open, is ignored and sets `acc_err`. This includes a strobe after the buffer has been released.
- R7: Every buffer command clears `acc_err` and `acc_ovf`. Outside commands both flags hold their value.
- R8: `in_ready[ep]` rises on the second clock edge after the write that fills byte N+2 and closes the session. `usb_in_ack` with `usb_in_ep` clears it.
- R9: With `dma_sel`=1 at the command, the first strobe accesses byte 2, which is word 1 on the 16-bit bus.
- R10: During a DMA read, `acc_eop` accompanies the one strobe whose data covers the last payload byte given by the stored length. Non-DMA reads never raise it.
- R11: A `dma_eot` pulse during a DMA write releases the buffer as if it were full. For any DMA write release, word 0 is overwritten with the number of payload bytes stored.
- R12: Code 0xF6 has no data phase and resets every register exactly like `rst`. Ready flags, error flags and the open session are all cleared.
- R13: Any other code (0x00, 0x11, 0x20..0xFF except 0xF6) is ignored: an open session keeps its pointer and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| bus16 | input | 1 | Data phase uses 16-bit words (sampled with a buffer command) |
| dma_sel | input | 1 | Data phase is run by DMA (sampled with a buffer command) |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 16 | Write data (bits 7:0 in byte mode) |
| acc_rd | input | 1 | Read strobe |
| acc_rdata | output | 16 | Read data |
| acc_rvalid | output | 1 | Read data valid, one clock after the strobe |
| acc_eop | output | 1 | Last payload data of a DMA read |
| dma_eot | input | 1 | External end of a DMA transfer |
| acc_err | output | 1 | Wrong-direction or sessionless access seen |
| acc_ovf | output | 1 | Access past the buffer limit seen |
| in_ready | output | NUM_EP | IN buffer released for transmission |
| usb_out_we | input | 1 | Serial side writes an OUT buffer word |
| usb_out_ep | input | EPW | OUT endpoint for the write |
| usb_out_widx | input | WIW | Word index for the write |
| usb_out_wdata | input | 16 | Word to write |
| usb_in_ep | input | EPW | IN endpoint for read and acknowledge |
| usb_in_widx | input | WIW | Word index to read |
| usb_in_rdata | output | 16 | IN buffer word, one clock after the address |
| usb_in_ack | input | 1 | Packet of `usb_in_ep` sent, clear its ready flag |

## Verification
Read data, its valid flag and the end-of-packet flag register on the edge that samples the strobe. Error and overflow flags do the same, and a command acts on the edge that samples it. The bench drives each input on a falling edge, releases it on the next falling edge and samples there, half a clock after the edge that acts on it. A buffer release takes one more edge, so ready and header checks wait an extra clock. The serial-side read port has one edge of latency, so the bench sets the address a full clock before it reads the word back.

// File: rtl/epb_pkg.sv
package epb_pkg;
  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_WRITE,
    CMD_READ,
    CMD_RESET
  } cmd_kind_e;

  localparam logic [7:0] SOFT_RESET_CODE = 8'hF6;
endpackage

// File: rtl/epb_decode.sv
module epb_decode
  import epb_pkg::*;
#(
  parameter int NUM_EP = 15,
  parameter int EPW    = 4
) (
  input  logic [7:0]     code,
  output cmd_kind_e      kind,
  output logic [EPW-1:0] ep
);
  logic [4:0] idx;

  always_comb begin
    kind = CMD_NONE;
    idx  = '0;
    if (code == SOFT_RESET_CODE) begin
      kind = CMD_RESET;
    end else if (code[7:4] == 4'h0 && code[3:0] != 4'h0) begin
      idx = {1'b0, code[3:0] - 4'd1};
      if (int'(idx) < NUM_EP) kind = CMD_WRITE;
    end else if (code[7:4] == 4'h1 && code[3:0] != 4'h1) begin
      idx = (code[3:0] == 4'h0) ? 5'd0 : {1'b0, code[3:0] - 4'd1};
      if (int'(idx) < NUM_EP) kind = CMD_READ;
    end
    ep = EPW'(idx);
  end
endmodule

// File: rtl/epb_bram.sv
module epb_bram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic [1:0]    a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [15:0]   a_wdata,
  input  logic [AW-1:0] b_addr,
  output logic [15:0]   b_rdata
);
  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (a_we[l]) mem[a_addr] <= a_wdata[8*l +: 8];
      q <= mem[b_addr];
    end
    assign b_rdata[8*l +: 8] = q;
  end
endmodule

// File: rtl/ep_buf_access.sv
module ep_buf_access
  import epb_pkg::*;
#(
  parameter int NUM_EP      = 15,
  parameter int MAX_PAYLOAD = 64,
  localparam int BUF_BYTES  = MAX_PAYLOAD + 2,
  localparam int WORDS      = (BUF_BYTES + 1) / 2,
  localparam int EPW        = $clog2(NUM_EP),
  localparam int WIW        = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              bus16,
  input  logic              dma_sel,
  input  logic              acc_wr,
  input  logic [15:0]       acc_wdata,
  input  logic              acc_rd,
  output logic [15:0]       acc_rdata,
  output logic              acc_rvalid,
  output logic              acc_eop,
  input  logic              dma_eot,
  output logic              acc_err,
  output logic              acc_ovf,
  output logic [NUM_EP-1:0] in_ready,
  input  logic              usb_out_we,
  input  logic [EPW-1:0]    usb_out_ep,
  input  logic [WIW-1:0]    usb_out_widx,
  input  logic [15:0]       usb_out_wdata,
  input  logic [EPW-1:0]    usb_in_ep,
  input  logic [WIW-1:0]    usb_in_widx,
  output logic [15:0]       usb_in_rdata,
  input  logic              usb_in_ack
);
  localparam int DEPTH = NUM_EP * WORDS;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = $clog2(BUF_BYTES + 1);
  localparam logic [PW:0] LIMIT = (PW+1)'(BUF_BYTES);

  function automatic logic [AW-1:0] addr_of(input logic [EPW-1:0] ep, input int widx);
    return AW'(int'(ep) * WORDS + widx);
  endfunction

  cmd_kind_e      kind;
  logic [EPW-1:0] dec_ep;

  epb_decode #(.NUM_EP(NUM_EP), .EPW(EPW)) u_decode (
    .code(cmd_code), .kind(kind), .ep(dec_ep)
  );

  // session state
  logic              sess_open, sess_rd, sess_wide, sess_dma;
  logic [EPW-1:0]    sess_ep;
  logic [PW-1:0]     ptr;
  logic              fin_pend, len_cap;
  logic [15:0]       pkt_len;
  logic              err_q, ovf_q, rvalid_q, eop_q, bsel_q;
  logic [NUM_EP-1:0] ready_q;
  logic [15:0]       out_q;

  logic        srst, buf_cmd, fits, wr_ok, rd_ok, dir_bad, ovf_hit, eot_hit, eop_hit;
  logic [PW:0] step, nxt;
  logic [16:0] lim;
  logic [AW-1:0] acc_addr;

  always_comb begin
    srst     = rst || (cmd_valid && kind == CMD_RESET);
    buf_cmd  = cmd_valid && (kind == CMD_WRITE || kind == CMD_READ);
    step     = sess_wide ? (PW+1)'(2) : (PW+1)'(1);
    nxt      = {1'b0, ptr} + step;
    fits     = nxt <= LIMIT;
    acc_addr = addr_of(sess_ep, int'(ptr[PW-1:1]));
    wr_ok    = !buf_cmd && acc_wr && sess_open && !sess_rd && !fin_pend && fits;
    rd_ok    = !buf_cmd && acc_rd && sess_open && sess_rd && fits;
    dir_bad  = !buf_cmd && ((acc_wr && !(sess_open && !sess_rd)) ||
                            (acc_rd && !(sess_open && sess_rd)));
    ovf_hit  = !buf_cmd && ((acc_wr && sess_open && !sess_rd && (fin_pend || !fits)) ||
                            (acc_rd && sess_open && sess_rd && !fits));
    eot_hit  = !buf_cmd && dma_eot && sess_open && !sess_rd && sess_dma && !fin_pend;
    lim      = {1'b0, (len_cap ? out_q : pkt_len)} + 17'd2;
    eop_hit  = rd_ok && sess_dma && (17'(ptr) < lim) && (17'(nxt) >= lim);
  end

  // IN buffers: written by the microcontroller, read by the serial engine
  logic [1:0]    in_we;
  logic [AW-1:0] in_addr;
  logic [15:0]   in_wdata;

  always_comb begin
    in_we    = 2'b00;
    in_addr  = acc_addr;
    in_wdata = sess_wide ? acc_wdata : {acc_wdata[7:0], acc_wdata[7:0]};
    if (fin_pend && sess_dma) begin
      in_we    = 2'b11;
      in_addr  = addr_of(sess_ep, 0);
      in_wdata = 16'(ptr) - 16'd2;
    end else if (wr_ok) begin
      in_we = sess_wide ? 2'b11 : (ptr[0] ? 2'b10 : 2'b01);
    end
  end

  epb_bram #(.DEPTH(DEPTH), .AW(AW)) u_in_mem (
    .clk(clk), .a_we(in_we), .a_addr(in_addr), .a_wdata(in_wdata),
    .b_addr(addr_of(usb_in_ep, int'(usb_in_widx))), .b_rdata(usb_in_rdata)
  );

  // OUT buffers: written by the serial engine, read by the microcontroller
  epb_bram #(.DEPTH(DEPTH), .AW(AW)) u_out_mem (
    .clk(clk), .a_we({2{usb_out_we}}),
    .a_addr(addr_of(usb_out_ep, int'(usb_out_widx))), .a_wdata(usb_out_wdata),
    .b_addr(buf_cmd ? addr_of(dec_ep, 0) : acc_addr), .b_rdata(out_q)
  );

  always_ff @(posedge clk) begin
    if (srst) begin
      sess_open <= 1'b0;
      sess_rd   <= 1'b0;
      sess_wide <= 1'b0;
      sess_dma  <= 1'b0;
      sess_ep   <= '0;
      ptr       <= '0;
      fin_pend  <= 1'b0;
      len_cap   <= 1'b0;
      pkt_len   <= '0;
      err_q     <= 1'b0;
      ovf_q     <= 1'b0;
      rvalid_q  <= 1'b0;
      eop_q     <= 1'b0;
      bsel_q    <= 1'b0;
      ready_q   <= '0;
    end else begin
      rvalid_q <= rd_ok;
      eop_q    <= eop_hit;
      bsel_q   <= ptr[0];
      if (len_cap) begin
        pkt_len <= out_q;
        len_cap <= 1'b0;
      end
      if (usb_in_ack) ready_q[usb_in_ep] <= 1'b0;
      if (fin_pend) begin
        ready_q[sess_ep] <= 1'b1;
        fin_pend         <= 1'b0;
        sess_open        <= 1'b0;
      end
      if (wr_ok || rd_ok) ptr <= nxt[PW-1:0];
      if ((wr_ok && nxt == LIMIT) || eot_hit) fin_pend <= 1'b1;
      if (buf_cmd) begin
        sess_open <= 1'b1;
        sess_rd   <= (kind == CMD_READ);
        sess_ep   <= dec_ep;
        sess_wide <= bus16;
        sess_dma  <= dma_sel;
        ptr       <= dma_sel ? PW'(2) : '0;
        len_cap   <= (kind == CMD_READ) && dma_sel;
        err_q     <= 1'b0;
        ovf_q     <= 1'b0;
      end else begin
        err_q <= err_q | dir_bad;
        ovf_q <= ovf_q | ovf_hit;
      end
    end
  end

  assign acc_rdata  = sess_wide ? out_q : {8'h00, bsel_q ? out_q[15:8] : out_q[7:0]};
  assign acc_rvalid = rvalid_q;
  assign acc_eop    = eop_q;
  assign acc_err    = err_q;
  assign acc_ovf    = ovf_q;
  assign in_ready   = ready_q;
endmodule

// File: rtl/epb_chk.sv
module epb_chk #(
  parameter int NUM_EP = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [7:0]        cmd_code,
  input logic              acc_wr,
  input logic              acc_rd,
  input logic              dma_eot,
  input logic              acc_rvalid,
  input logic              acc_eop,
  input logic              acc_err,
  input logic              acc_ovf,
  input logic [NUM_EP-1:0] in_ready
);
  logic buf_code;
  assign buf_code = (int'(cmd_code) >= 1 && int'(cmd_code) <= NUM_EP) ||
                    cmd_code == 8'h10 ||
                    (int'(cmd_code) >= 18 && int'(cmd_code) <= 16 + NUM_EP);

  // R3: read data only follows a read strobe
  a_r3_rvalid_follows_rd: assert property (@(posedge clk) disable iff (rst)
    acc_rvalid |-> $past(acc_rd));

  // R10: end of packet only travels with data
  a_r10_eop_with_data: assert property (@(posedge clk) disable iff (rst)
    acc_eop |-> acc_rvalid);

  // R6: error flag is sticky outside commands
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (acc_err && !cmd_valid) |=> acc_err);

  // R7: buffer commands clear both flags
  a_r7_flags_clear: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && buf_code) |=> (!acc_err && !acc_ovf));

  // R12: soft reset code empties every flag
  a_r12_soft_reset: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 8'hF6) |=> (in_ready == '0 && !acc_err && !acc_ovf));

  // R8 / R11: a ready flag rises only two edges after a write or end of transfer
  a_r8_ready_source: assert property (@(posedge clk) disable iff (rst)
    ($countones(in_ready) > $countones($past(in_ready))) |->
      ($past(acc_wr, 2) || $past(dma_eot, 2)));
endmodule

bind ep_buf_access epb_chk #(.NUM_EP(NUM_EP)) u_chk (.*);

// File: tb/ep_buf_access_tb.sv
module ep_buf_access_tb;
  localparam int NEP = 15;
  localparam int N   = 8;
  localparam int BUF = N + 2;
  localparam int EPW = $clog2(NEP);
  localparam int WIW = $clog2((BUF + 1) / 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 0, bus16 = 0, dma_sel = 0, acc_wr = 0, acc_rd = 0, dma_eot = 0;
  logic [7:0] cmd_code = '0;
  logic [15:0] acc_wdata = '0, acc_rdata, usb_out_wdata = '0, usb_in_rdata;
  logic acc_rvalid, acc_eop, acc_err, acc_ovf, usb_out_we = 0, usb_in_ack = 0;
  logic [NEP-1:0] in_ready;
  logic [EPW-1:0] usb_out_ep = '0, usb_in_ep = '0;
  logic [WIW-1:0] usb_out_widx = '0, usb_in_widx = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ep_buf_access #(.NUM_EP(NEP), .MAX_PAYLOAD(N)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] c, input logic w, input logic d);
    cmd_valid = 1; cmd_code = c; bus16 = w; dma_sel = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wr(input logic [15:0] d);
    acc_wr = 1; acc_wdata = d;
    @(negedge clk);
    acc_wr = 0;
  endtask

  task automatic rd(output logic [15:0] d, output logic v, output logic e);
    acc_rd = 1;
    @(negedge clk);
    acc_rd = 0;
    d = acc_rdata; v = acc_rvalid; e = acc_eop;
  endtask

  task automatic usb_put(input int ep, input int wi, input logic [15:0] d);
    usb_out_we = 1; usb_out_ep = EPW'(ep); usb_out_widx = WIW'(wi); usb_out_wdata = d;
    @(negedge clk);
    usb_out_we = 0;
  endtask

  task automatic usb_get(input int ep, input int wi, output logic [15:0] d);
    usb_in_ep = EPW'(ep); usb_in_widx = WIW'(wi);
    @(negedge clk);
    d = usb_in_rdata;
  endtask

  task automatic t_reset();
    chk("R1 in_ready", 32'(in_ready), 0);
    chk("R1 flags", {acc_err, acc_ovf, acc_rvalid, acc_eop}, 0);
  endtask

  task automatic t_byte_fill();
    logic [15:0] w;
    cmd(8'h03, 0, 0);
    for (int i = 0; i < BUF; i++) begin
      wr(16'(i == 0 ? 8'h08 : (i == 1 ? 8'h00 : 8'h40 + i)));
      if (i == BUF - 2) chk("R8 not ready early", 32'(in_ready[2]), 0);
    end
    @(negedge clk);
    chk("R8 ready after fill", 32'(in_ready[2]), 1);
    usb_get(2, 0, w); chk("R2 header word", w, 16'h0008);
    usb_get(2, 1, w); chk("R2 R4 byte order", w, 16'h4342);
    usb_get(2, 4, w); chk("R2 last word", w, 16'h4948);
    usb_in_ep = 2; usb_in_ack = 1;
    @(negedge clk);
    usb_in_ack = 0;
    chk("R8 ack clears", 32'(in_ready[2]), 0);
  endtask

  task automatic t_word_ovf();
    logic [15:0] w;
    cmd(8'h01, 1, 0);
    wr(16'h0008);
    for (int k = 1; k < BUF / 2; k++) wr(16'hA000 + 16'(k));
    wr(16'hDEAD);
    chk("R5 overflow in release cycle", 32'(acc_ovf), 1);
    chk("R6 no error", 32'(acc_err), 0);
    chk("R8 word fill ready", 32'(in_ready[0]), 1);
    usb_get(0, 4, w); chk("R5 ignored write", w, 16'hA004);
    usb_get(0, 2, w); chk("R4 word step", w, 16'hA002);
  endtask

  task automatic t_read();
    logic [15:0] d; logic v, e;
    logic [7:0] exp_b [BUF] = '{8'h06, 8'h00, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6, 8'h07, 8'h18};
    usb_put(5, 0, 16'h0006); usb_put(5, 1, 16'hB2A1); usb_put(5, 2, 16'hD4C3);
    usb_put(5, 3, 16'hF6E5); usb_put(5, 4, 16'h1807);
    cmd(8'h16, 0, 0);
    for (int i = 0; i < BUF; i++) begin
      rd(d, v, e);
      chk("R3 R4 byte read", {15'd0, v, d}, {15'd0, 1'b1, 8'h00, exp_b[i]});
      if (i == BUF - 1) chk("R10 no eop without DMA", 32'(e), 0);
    end
    rd(d, v, e);
    chk("R5 read past limit", {v, acc_ovf}, 2'b01);
    usb_put(0, 1, 16'h5A3C);
    cmd(8'h10, 1, 0);
    rd(d, v, e); rd(d, v, e);
    chk("R3 code 10 word", d, 16'h5A3C);
    usb_put(14, 0, 16'h7E11);
    cmd(8'h1F, 1, 0);
    rd(d, v, e);
    chk("R3 code 1F", {v, d}, {1'b1, 16'h7E11});
  endtask

  task automatic t_dma_read();
    logic [15:0] d; logic v, e;
    usb_put(5, 0, 16'h0005);
    cmd(8'h16, 1, 1);
    rd(d, v, e); chk("R9 first DMA word", {e, d}, {1'b0, 16'hB2A1});
    rd(d, v, e); chk("R10 mid word", {e, d}, {1'b0, 16'hD4C3});
    rd(d, v, e); chk("R10 eop on last word", {e, d}, {1'b1, 16'hF6E5});
    rd(d, v, e); chk("R10 eop once", 32'(e), 0);
    cmd(8'h16, 0, 1);
    for (int i = 0; i < 5; i++) begin
      rd(d, v, e);
      chk("R10 byte DMA eop", {e, d[7:0]}, {(i == 4), 8'hA1 + 8'(i * 17)});
    end
  endtask

  task automatic t_dma_write();
    logic [15:0] w;
    cmd(8'h05, 0, 1);
    wr(16'h31); wr(16'h32); wr(16'h33);
    dma_eot = 1;
    @(negedge clk);
    dma_eot = 0;
    @(negedge clk);
    chk("R11 eot releases", 32'(in_ready[4]), 1);
    usb_get(4, 0, w); chk("R11 header count", w, 16'h0003);
    usb_get(4, 1, w); chk("R9 DMA starts at byte 2", w, 16'h3231);
    usb_get(4, 2, w); chk("R11 partial byte", 32'(w[7:0]), 32'h33);
    wr(16'h99);
    chk("R6 write after release", 32'(acc_err), 1);
    cmd(8'h06, 1, 1);
    wr(16'h0102); wr(16'h0304); wr(16'h0506); wr(16'h0708);
    @(negedge clk);
    chk("R11 DMA full ready", 32'(in_ready[5]), 1);
    usb_get(5, 0, w); chk("R11 full header", w, 16'h0008);
    usb_get(5, 1, w); chk("R9 word DMA start", w, 16'h0102);
  endtask

  task automatic t_dir_err();
    logic [15:0] d; logic v, e;
    cmd(8'h02, 0, 0);
    rd(d, v, e);
    chk("R6 read in write session", {v, acc_err}, 2'b01);
    cmd(8'h14, 0, 0);
    chk("R7 command clears", {acc_err, acc_ovf}, 0);
    wr(16'h55);
    chk("R6 write in read session", 32'(acc_err), 1);
  endtask

  task automatic t_invalid();
    logic [15:0] w;
    cmd(8'h07, 0, 0);
    for (int i = 0; i < 4; i++) wr(16'(i == 0 ? 8'h08 : (i == 1 ? 8'h00 : 8'h60 + i)));
    cmd(8'h11, 1, 1); cmd(8'h00, 1, 1); cmd(8'h2A, 1, 1);
    for (int i = 4; i < BUF; i++) wr(16'(8'h60 + i));
    @(negedge clk);
    chk("R13 session kept", {in_ready[6], acc_err}, 2'b10);
    usb_get(6, 2, w); chk("R13 pointer kept", w, 16'h6564);
  endtask

  task automatic t_soft_reset();
    logic [15:0] d; logic v, e;
    rd(d, v, e);
    chk("R6 no session", 32'(acc_err), 1);
    cmd(8'hF6, 0, 0);
    chk("R12 ready cleared", 32'(in_ready), 0);
    chk("R12 flags cleared", {acc_err, acc_ovf}, 0);
    wr(16'h12);
    chk("R12 session closed", 32'(acc_err), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_byte_fill();
    t_word_ovf();
    t_read();
    t_dma_read();
    t_dma_write();
    t_dir_err();
    t_invalid();
    t_soft_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule